// File: doc/BRIEF.md
# Dual Serial Audio Port Mode Router

This block connects three audio paths to two serial audio ports: stereo playback, voice playback and capture. One port is the stereo port, with a bit clock, a frame clock and serial data in and out. The other is the voice port, with the same set of signals. A 2-bit interface-mode field decides which port carries each path. It also decides which bit clock and which frame clock each path is timed to. In one mode, capture shares the stereo bit clock but takes its frame clock from the voice port, so capture and playback can run at different sample rates.

Word length and format are chosen per path, not per port. Stereo playback always uses the stereo configuration fields. Voice playback and capture always use the voice fields, even when the stereo port carries them. The chosen fields go to the converter side with each path. A dual-output control copies capture data onto both serial data outputs at once.

A new mode takes effect at the next rising edge of the stereo frame clock, so a frame already in progress is never split. The port clocks and serial data are treated as signals that are already synchronous to the block clock `clk`.

Top module: `audio_if_router`

## Requirements
- R1: With active mode 2'b00, stereo playback takes stereo-port data and clocks. Voice playback takes voice-port data, bit clock and frame clock. Capture is timed to the voice-port clocks and its data leaves on the voice-port output.
- R2: With active mode 2'b01, voice playback takes stereo-port data, bit clock and frame clock. Capture is timed to the stereo-port clocks and leaves on the stereo-port output. Stereo playback is disabled.
- R3: With active mode 2'b10, stereo playback and capture both use the stereo bit clock and stereo frame clock. Capture leaves on the stereo-port output.
- R4: With active mode 2'b11, stereo playback uses the stereo bit clock and frame clock. Capture uses the stereo bit clock with the voice-port frame clock, and leaves on the stereo-port output.
- R5: The word-length code (2 bits: 0=16, 1=20, 2=24, 3=32 bits) and format code (2 bits: 0=right-justified, 1=left-justified, 2=I2S, 3=DSP) of stereo playback always come from the stereo fields. Those of voice playback and capture always come from the voice fields, in every mode.
- R6: When the dual-output control is 1, capture data appears on both the stereo-port and voice-port serial outputs. When it is 0, the serial output that is not selected is held at 0.
- R7: A disabled path (stereo playback in mode 2'b01, voice playback in modes 2'b10 and 2'b11) drives its data, bit clock and frame clock outputs at 0 and ignores its serial input.
- R8: A change on the mode input becomes active only at the first clk edge that samples the stereo frame clock high after it was sampled low. Until then, routing follows the previous mode.
- R9: After reset the active mode is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| ifMode | input | 2 | Requested interface mode |
| dualOut | input | 1 | Copy capture data onto both serial outputs |
| stWl | input | 2 | Stereo word-length code |
| stFmt | input | 2 | Stereo format code |
| vcWl | input | 2 | Voice word-length code |
| vcFmt | input | 2 | Voice format code |
| stBclk | input | 1 | Stereo-port bit clock |
| stLrck | input | 1 | Stereo-port frame clock |
| vcBclk | input | 1 | Voice-port bit clock |
| vcFs | input | 1 | Voice-port frame clock |
| stDin | input | 1 | Stereo-port serial data in |
| vcDin | input | 1 | Voice-port serial data in |
| capIn | input | 1 | Serial capture data from the converter side |
| hifiPlayData | output | 1 | Stereo playback serial data |
| hifiPlayBclk | output | 1 | Stereo playback bit clock |
| hifiPlayFrm | output | 1 | Stereo playback frame clock |
| hifiPlayWl | output | 2 | Stereo playback word-length code |
| hifiPlayFmt | output | 2 | Stereo playback format code |
| voicePlayData | output | 1 | Voice playback serial data |
| voicePlayBclk | output | 1 | Voice playback bit clock |
| voicePlayFrm | output | 1 | Voice playback frame clock |
| voicePlayWl | output | 2 | Voice playback word-length code |
| voicePlayFmt | output | 2 | Voice playback format code |
| capBclk | output | 1 | Capture bit clock |
| capFrm | output | 1 | Capture frame clock |
| capWl | output | 2 | Capture word-length code |
| capFmt | output | 2 | Capture format code |
| stDout | output | 1 | Stereo-port serial data out |
| vcDout | output | 1 | Voice-port serial data out |

## Verification
The bench drives each mode with bit patterns in which the stereo and voice clocks differ, so a design that swaps the port sources shows the wrong bit at once. In split-rate mode, capture must take the stereo bit clock but the voice frame clock; a design that takes both clocks from one port fails there. Disabled paths are driven with active inputs and must stay at 0, and a design that forwards them is reported. The bench changes the mode request with no frame edge to catch a design that switches early. It also checks that the configuration fields follow the path and not the port, which would fail if voice settings were dropped when voice traffic moves to the stereo port.

// File: rtl/audio_if_router_pkg.sv
package audio_if_router_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_SPLIT      = 2'b00,
    MODE_VOICE_ON_ST = 2'b01,
    MODE_HIFI_SHARED = 2'b10,
    MODE_HIFI_DUALFS = 2'b11
  } ifMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic frameEdge;
    logic modeLoad;
  } routerStrobe_t;

endpackage

// File: rtl/audio_if_router_ctrl.sv
module audio_if_router_ctrl
  import audio_if_router_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stLrck,
  input  logic [MODE_W-1:0]    reqMode,
  input  logic [MODE_W-1:0]    curMode,
  output routerStrobe_t        strobe
);

  logic lrckQ;

  always_ff @(posedge clk) begin
    if (!rstN) lrckQ <= 1'b0;
    else       lrckQ <= stLrck;
  end

  always_comb begin
    strobe.frameEdge = stLrck & ~lrckQ;
    strobe.modeLoad  = strobe.frameEdge && (reqMode != curMode);
  end

endmodule

// File: rtl/audio_if_router_dp.sv
module audio_if_router_dp
  import audio_if_router_pkg::*;
#(
  parameter int WL_W  = 2,
  parameter int FMT_W = 2,
  parameter logic [MODE_W-1:0] RESET_MODE = MODE_SPLIT
) (
  input  logic               clk,
  input  logic               rstN,
  input  routerStrobe_t      strobe,
  input  logic [MODE_W-1:0]  reqMode,
  input  logic               dualOut,
  input  logic [WL_W-1:0]    stWl,
  input  logic [FMT_W-1:0]   stFmt,
  input  logic [WL_W-1:0]    vcWl,
  input  logic [FMT_W-1:0]   vcFmt,
  input  logic               stBclk,
  input  logic               stLrck,
  input  logic               vcBclk,
  input  logic               vcFs,
  input  logic               stDin,
  input  logic               vcDin,
  input  logic               capIn,
  output logic [MODE_W-1:0]  curMode,
  output logic               hifiPlayData,
  output logic               hifiPlayBclk,
  output logic               hifiPlayFrm,
  output logic [WL_W-1:0]    hifiPlayWl,
  output logic [FMT_W-1:0]   hifiPlayFmt,
  output logic               voicePlayData,
  output logic               voicePlayBclk,
  output logic               voicePlayFrm,
  output logic [WL_W-1:0]    voicePlayWl,
  output logic [FMT_W-1:0]   voicePlayFmt,
  output logic               capBclk,
  output logic               capFrm,
  output logic [WL_W-1:0]    capWl,
  output logic [FMT_W-1:0]   capFmt,
  output logic               stDout,
  output logic               vcDout
);

  ifMode_e modeQ;
  logic    capOnVoicePort;

  always_ff @(posedge clk) begin
    if (!rstN)                modeQ <= ifMode_e'(RESET_MODE);
    else if (strobe.modeLoad) modeQ <= ifMode_e'(reqMode);
  end

  assign curMode = modeQ;

  // Per-path configuration follows the path, never the port
  assign hifiPlayWl   = stWl;
  assign hifiPlayFmt  = stFmt;
  assign voicePlayWl  = vcWl;
  assign voicePlayFmt = vcFmt;
  assign capWl        = vcWl;
  assign capFmt       = vcFmt;

  always_comb begin
    hifiPlayData  = 1'b0;
    hifiPlayBclk  = 1'b0;
    hifiPlayFrm   = 1'b0;
    voicePlayData = 1'b0;
    voicePlayBclk = 1'b0;
    voicePlayFrm  = 1'b0;
    capBclk       = stBclk;
    capFrm        = stLrck;
    capOnVoicePort = 1'b0;
    unique case (modeQ)
      MODE_SPLIT: begin
        hifiPlayData   = stDin;
        hifiPlayBclk   = stBclk;
        hifiPlayFrm    = stLrck;
        voicePlayData  = vcDin;
        voicePlayBclk  = vcBclk;
        voicePlayFrm   = vcFs;
        capBclk        = vcBclk;
        capFrm         = vcFs;
        capOnVoicePort = 1'b1;
      end
      MODE_VOICE_ON_ST: begin
        voicePlayData = stDin;
        voicePlayBclk = stBclk;
        voicePlayFrm  = stLrck;
      end
      MODE_HIFI_SHARED: begin
        hifiPlayData = stDin;
        hifiPlayBclk = stBclk;
        hifiPlayFrm  = stLrck;
      end
      MODE_HIFI_DUALFS: begin
        hifiPlayData = stDin;
        hifiPlayBclk = stBclk;
        hifiPlayFrm  = stLrck;
        capFrm       = vcFs;
      end
      default: ;
    endcase
  end

  always_comb begin
    stDout = (capOnVoicePort ? dualOut : 1'b1) & capIn;
    vcDout = (capOnVoicePort ? 1'b1 : dualOut) & capIn;
  end

endmodule

// File: rtl/audio_if_router.sv
module audio_if_router
  import audio_if_router_pkg::*;
#(
  parameter int WL_W  = 2,
  parameter int FMT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       ifMode,
  input  logic             dualOut,
  input  logic [WL_W-1:0]  stWl,
  input  logic [FMT_W-1:0] stFmt,
  input  logic [WL_W-1:0]  vcWl,
  input  logic [FMT_W-1:0] vcFmt,
  input  logic             stBclk,
  input  logic             stLrck,
  input  logic             vcBclk,
  input  logic             vcFs,
  input  logic             stDin,
  input  logic             vcDin,
  input  logic             capIn,
  output logic             hifiPlayData,
  output logic             hifiPlayBclk,
  output logic             hifiPlayFrm,
  output logic [WL_W-1:0]  hifiPlayWl,
  output logic [FMT_W-1:0] hifiPlayFmt,
  output logic             voicePlayData,
  output logic             voicePlayBclk,
  output logic             voicePlayFrm,
  output logic [WL_W-1:0]  voicePlayWl,
  output logic [FMT_W-1:0] voicePlayFmt,
  output logic             capBclk,
  output logic             capFrm,
  output logic [WL_W-1:0]  capWl,
  output logic [FMT_W-1:0] capFmt,
  output logic             stDout,
  output logic             vcDout
);

  routerStrobe_t       strobe;
  logic [MODE_W-1:0]   curMode;

  audio_if_router_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .stLrck  (stLrck),
    .reqMode (ifMode),
    .curMode (curMode),
    .strobe  (strobe)
  );

  audio_if_router_dp #(
    .WL_W  (WL_W),
    .FMT_W (FMT_W)
  ) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .reqMode       (ifMode),
    .dualOut       (dualOut),
    .stWl          (stWl),
    .stFmt         (stFmt),
    .vcWl          (vcWl),
    .vcFmt         (vcFmt),
    .stBclk        (stBclk),
    .stLrck        (stLrck),
    .vcBclk        (vcBclk),
    .vcFs          (vcFs),
    .stDin         (stDin),
    .vcDin         (vcDin),
    .capIn         (capIn),
    .curMode       (curMode),
    .hifiPlayData  (hifiPlayData),
    .hifiPlayBclk  (hifiPlayBclk),
    .hifiPlayFrm   (hifiPlayFrm),
    .hifiPlayWl    (hifiPlayWl),
    .hifiPlayFmt   (hifiPlayFmt),
    .voicePlayData (voicePlayData),
    .voicePlayBclk (voicePlayBclk),
    .voicePlayFrm  (voicePlayFrm),
    .voicePlayWl   (voicePlayWl),
    .voicePlayFmt  (voicePlayFmt),
    .capBclk       (capBclk),
    .capFrm        (capFrm),
    .capWl         (capWl),
    .capFmt        (capFmt),
    .stDout        (stDout),
    .vcDout        (vcDout)
  );

endmodule

// File: rtl/audio_if_router_chk.sv
module audio_if_router_chk #(
  parameter int WL_W  = 2,
  parameter int FMT_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       curMode,
  input logic             stLrck,
  input logic             stBclk,
  input logic             vcFs,
  input logic             dualOut,
  input logic [WL_W-1:0]  vcWl,
  input logic [FMT_W-1:0] vcFmt,
  input logic             hifiPlayData,
  input logic             hifiPlayBclk,
  input logic             hifiPlayFrm,
  input logic             voicePlayData,
  input logic             capBclk,
  input logic             capFrm,
  input logic [WL_W-1:0]  capWl,
  input logic [FMT_W-1:0] capFmt,
  input logic             stDout,
  input logic             vcDout
);

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(stLrck) |=> $stable(curMode));

  p_hifi_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'b01) |-> (!hifiPlayData && !hifiPlayBclk && !hifiPlayFrm));

  p_voice_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    curMode[1] |-> !voicePlayData);

  p_dual_copy_r6: assert property (@(posedge clk) disable iff (!rstN)
    dualOut |-> (stDout == vcDout));

  p_cap_cfg_r5: assert property (@(posedge clk) disable iff (!rstN)
    (capWl == vcWl) && (capFmt == vcFmt));

  p_dualfs_clk_r4: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'b11) |-> ((capBclk == stBclk) && (capFrm == vcFs)));

endmodule

bind audio_if_router audio_if_router_chk #(.WL_W(WL_W), .FMT_W(FMT_W)) i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .curMode       (curMode),
  .stLrck        (stLrck),
  .stBclk        (stBclk),
  .vcFs          (vcFs),
  .dualOut       (dualOut),
  .vcWl          (vcWl),
  .vcFmt         (vcFmt),
  .hifiPlayData  (hifiPlayData),
  .hifiPlayBclk  (hifiPlayBclk),
  .hifiPlayFrm   (hifiPlayFrm),
  .voicePlayData (voicePlayData),
  .capBclk       (capBclk),
  .capFrm        (capFrm),
  .capWl         (capWl),
  .capFmt        (capFmt),
  .stDout        (stDout),
  .vcDout        (vcDout)
);

// File: tb/test_audio_if_router.sv
module test_audio_if_router;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] ifMode = 2'b00;
  logic dualOut = 1'b0;
  logic [1:0] stWl = 2'b01, stFmt = 2'b10, vcWl = 2'b11, vcFmt = 2'b00;
  logic stBclk = 1'b0, stLrck = 1'b0, vcBclk = 1'b0, vcFs = 1'b0;
  logic stDin = 1'b0, vcDin = 1'b0, capIn = 1'b0;
  logic hifiPlayData, hifiPlayBclk, hifiPlayFrm;
  logic [1:0] hifiPlayWl, hifiPlayFmt;
  logic voicePlayData, voicePlayBclk, voicePlayFrm;
  logic [1:0] voicePlayWl, voicePlayFmt;
  logic capBclk, capFrm;
  logic [1:0] capWl, capFmt;
  logic stDout, vcDout;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  audio_if_router i_audio_if_router (
    .clk(clk), .rstN(rstN), .ifMode(ifMode), .dualOut(dualOut),
    .stWl(stWl), .stFmt(stFmt), .vcWl(vcWl), .vcFmt(vcFmt),
    .stBclk(stBclk), .stLrck(stLrck), .vcBclk(vcBclk), .vcFs(vcFs),
    .stDin(stDin), .vcDin(vcDin), .capIn(capIn),
    .hifiPlayData(hifiPlayData), .hifiPlayBclk(hifiPlayBclk), .hifiPlayFrm(hifiPlayFrm),
    .hifiPlayWl(hifiPlayWl), .hifiPlayFmt(hifiPlayFmt),
    .voicePlayData(voicePlayData), .voicePlayBclk(voicePlayBclk), .voicePlayFrm(voicePlayFrm),
    .voicePlayWl(voicePlayWl), .voicePlayFmt(voicePlayFmt),
    .capBclk(capBclk), .capFrm(capFrm), .capWl(capWl), .capFmt(capFmt),
    .stDout(stDout), .vcDout(vcDout)
  );

  // stimulus {mode[1:0], dual, stDin, vcDin, capIn, stBclk, stLrck, vcBclk, vcFs}
  // expected {hifiData, hifiBclk, hifiFrm, voiceData, voiceBclk, voiceFrm, capBclk, capFrm, stDout, vcDout}
  localparam int NVEC = 9;
  localparam logic [19:0] VECS [NVEC] = '{
    {10'b00_0_101_1001, 10'b110_001_01_01},
    {10'b00_1_011_0110, 10'b001_110_10_11},
    {10'b01_0_111_1100, 10'b000_111_11_10},
    {10'b01_1_011_0011, 10'b000_000_00_11},
    {10'b10_0_111_1011, 10'b110_000_10_10},
    {10'b10_1_010_0110, 10'b001_000_01_00},
    {10'b11_0_111_1100, 10'b111_000_10_10},
    {10'b11_1_001_0011, 10'b000_000_01_11},
    {10'b00_0_010_1111, 10'b011_111_11_00}
  };

  function automatic logic [9:0] observed();
    return {hifiPlayData, hifiPlayBclk, hifiPlayFrm, voicePlayData, voicePlayBclk,
            voicePlayFrm, capBclk, capFrm, stDout, vcDout};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Commit the requested mode with one stereo frame edge
  task automatic frameEdge();
    @(negedge clk) stLrck = 1'b0;
    @(negedge clk) stLrck = 1'b1;
    @(negedge clk) stLrck = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R9: reset mode 00 -> capture on voice port only
    @(negedge clk) capIn = 1'b1;
    #1 check("R9", {stDout, vcDout}, 2'b01);

    for (int i = 0; i < NVEC; i++) begin
      logic [9:0] s;
      string tag;
      s = VECS[i][19:10];
      ifMode = s[9:8];
      frameEdge();
      @(negedge clk);
      {dualOut, stDin, vcDin, capIn, stBclk, stLrck, vcBclk, vcFs} = s[7:0];
      #1;
      case (s[9:8])
        2'b00: tag = "R1";
        2'b01: tag = "R2";
        2'b10: tag = "R3";
        default: tag = "R4";
      endcase
      if (s[7]) tag = {tag, "/R6"};
      check(tag, observed(), VECS[i][9:0]);
      // R5: configuration follows path
      check("R5", {hifiPlayWl, hifiPlayFmt, voicePlayWl, voicePlayFmt, capWl, capFmt},
            {stWl, stFmt, vcWl, vcFmt, vcWl, vcFmt});
      @(negedge clk) stLrck = 1'b0;
    end

    // R7: mode 10, toggling voice input must leave voice playback at 0
    ifMode = 2'b10;
    frameEdge();
    @(negedge clk) {vcDin, vcBclk, vcFs} = 3'b111;
    #1 check("R7", {voicePlayData, voicePlayBclk, voicePlayFrm}, 3'b000);
    @(negedge clk) vcDin = 1'b0;
    #1 check("R7", {voicePlayData, voicePlayBclk, voicePlayFrm}, 3'b000);

    // R8: request mode 00 without frame edge; routing must stay in mode 10
    @(negedge clk) begin
      ifMode = 2'b00; dualOut = 1'b0; capIn = 1'b1; stLrck = 1'b0;
    end
    repeat (3) @(negedge clk);
    #1 check("R8", {stDout, vcDout}, 2'b10);
    @(negedge clk) stLrck = 1'b1;   // edge sampled at next posedge
    #1 check("R8", {stDout, vcDout}, 2'b10);
    @(negedge clk) stLrck = 1'b0;
    #1 check("R8", {stDout, vcDout}, 2'b01);

    // R5: new field values propagate in mode 01
    @(negedge clk) begin
      stWl = 2'b10; stFmt = 2'b11; vcWl = 2'b00; vcFmt = 2'b01; ifMode = 2'b01;
    end
    frameEdge();
    #1 check("R5", {voicePlayWl, voicePlayFmt, hifiPlayWl, hifiPlayFmt}, 8'b00_01_10_11);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule